// File: doc/BRIEF.md
# Processor debug halt controller

This block decides when a processor core enters and leaves the debug-halted state. It gathers halt requests from four places: the debug pin held low just after reset, a background command from the debug link, the trace buffer reaching its full threshold, and a hardware breakpoint. The debug-pin entry takes effect as soon as the post-reset window closes, and a background command reaching a stopped core halts it at once. The other requests are held pending until the core reports an instruction boundary. The serial link, the trace storage and the core pipeline sit outside the block and reach it as single-cycle strobes.

While halted, the block keeps a 4-bit halt-source field. Its low three bits hold a code for the highest-priority cause, and its top bit is a breakpoint flag that trace-full and breakpoint halts set. A status read clears the whole field. A resume clears only the cause code and the trace-full halt flag. On resume the block reports where execution continues: at a PC written during the halt, at the reset exception flow after a reset-into-halt, or at the next instruction. When debug is disabled or the device is secure, refused commands are answered with an illegal-command pulse.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `halt_req` is 0, `core_status` is 0, `halt_src` is 0, and `trace_halt_flag`, `resume_vld` and `illegal_rsp` are all 0.
- R2: When `dbg_pin_n` is low at the first two clock edges after `rst` falls, `halt_req` rises at the second of those edges and the cause code is 1. If the pin is high at either edge, the core runs.
- R3: A background, trace-full or breakpoint request made while running is held pending. The halt is taken at the first edge after the request edge at which `insn_sample` is high, and `halt_req` rises at that edge.
- R4: Cause codes are 1 for pin-reset entry, 2 for background, 3 for trace-full and 4 for breakpoint, carried in `halt_src[2:0]`. When several requests are pending, only the smallest code is reported.
- R5: A halt with a pending trace-full or breakpoint request sets `halt_src[3]` (mirrored on `bkpt_flag`). A halt with a pending trace-full request also sets `trace_halt_flag`.
- R6: `stat_read` clears all four bits of `halt_src` at the next edge, unless a halt is taken at that same edge, in which case the new cause is loaded.
- R7: An accepted `go_cmd` while halted returns the core to running at that edge. It clears `halt_src[2:0]` and `trace_halt_flag` and leaves `halt_src[3]` unchanged.
- R8: A permitted background command while stopped halts the core at that edge with cause 2, without waiting for `insn_sample`. The following resume reports next-instruction continuation.
- R9: An accepted resume gives a one-cycle `resume_vld` with `resume_sel` = 1 when a PC write was accepted during the halt, otherwise 2 when the halt came from pin-reset entry, otherwise 0.
- R10: A background command with `dbg_enable` low or `secure` high is ignored: no halt, nothing pended. `illegal_rsp` pulses for one cycle at the next edge.
- R11: While halted with `secure` high, `go_cmd` and `pc_write` are refused with an `illegal_rsp` pulse and the core stays halted. `stat_read` still works.
- R12: `core_status` shows 0 for running (and the post-reset window), 1 for stopped and 2 for halted, one cycle after the core state changes.
- R13: A `stop_enter` strobe while running, with no halt taken at that edge, moves the core to the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_pin_n | input | 1 | Debug pin level; low after reset requests halt entry |
| bgnd_cmd | input | 1 | Background command strobe |
| go_cmd | input | 1 | Resume command strobe |
| pc_write | input | 1 | PC write command strobe |
| stat_read | input | 1 | Status read strobe; clears the halt-source field |
| trace_full | input | 1 | Trace buffer reached its full threshold |
| bkpt_hit | input | 1 | Breakpoint match strobe |
| insn_sample | input | 1 | Instruction-boundary sample strobe from the core |
| stop_enter | input | 1 | Core executed a stop instruction |
| dbg_enable | input | 1 | Debug enabled |
| secure | input | 1 | Device is secure |
| halt_req | output | 1 | Core must be halted |
| core_status | output | 2 | 0 run, 1 stop, 2 halt |
| halt_src | output | 4 | {breakpoint flag, cause code} |
| bkpt_flag | output | 1 | Breakpoint flag, same as halt_src[3] |
| trace_halt_flag | output | 1 | Halt was caused by trace-full |
| resume_vld | output | 1 | One-cycle pulse on an accepted resume |
| resume_sel | output | 2 | Resume target: 0 next instruction, 1 loaded PC, 2 reset flow |
| illegal_rsp | output | 1 | One-cycle pulse for a refused command |

## Verification
The hardest state to reach is a secure halt entered through the reset path, because it needs a reset with the debug pin held low across the release edge and the following cycle. Only then can the bench show that resume and PC write are refused while a status read still clears the field. The bench builds this with a reset task that sets how many cycles the pin stays low. A later resume then shows that the refused PC write left the target at the reset flow. Stacked pending requests are produced by raising background, trace-full and breakpoint in one cycle and sampling later, and a long random stretch with reset, security and enable toggling is checked against a behavioural model every cycle.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2,
        ST_HALT = 2'd3
    } core_st_e;

    typedef enum logic [1:0] {
        RS_NEXT       = 2'd0,
        RS_LOADED_PC  = 2'd1,
        RS_RESET_FLOW = 2'd2
    } resume_e;

    localparam int CODE_W   = 3;
    localparam int NUM_PEND = 3;
    localparam int PEND_BG  = 0;
    localparam int PEND_TR  = 1;
    localparam int PEND_BK  = 2;

    localparam logic [CODE_W-1:0] CODE_NONE  = 3'd0;
    localparam logic [CODE_W-1:0] CODE_PIN   = 3'd1;
    localparam logic [CODE_W-1:0] CODE_FIRST = 3'd2;  // code of pending slot 0

    typedef struct packed {
        logic              bkpt;
        logic [CODE_W-1:0] code;
    } halt_src_t;

    // Lowest pending slot wins; slot i maps to code CODE_FIRST + i.
    function automatic logic [CODE_W-1:0] pick_code(input logic [NUM_PEND-1:0] p);
        logic [CODE_W-1:0] c;
        c = CODE_NONE;
        for (int i = NUM_PEND - 1; i >= 0; i--) begin
            if (p[i]) c = CODE_FIRST + CODE_W'(i);
        end
        return c;
    endfunction

    function automatic logic [1:0] status_of(input core_st_e s);
        case (s)
            ST_STOP: return 2'd1;
            ST_HALT: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/dbg_rst_entry.sv
module dbg_rst_entry #(
    parameter int MIN_LOW = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic boot_halt,
    output logic boot_run
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign boot_halt = active_q && !pin_n && (cnt_q == CNT_W'(MIN_LOW - 1));
    assign boot_run  = active_q && pin_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
        end else if (active_q) begin
            if (boot_halt || boot_run) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Window closes after its decision: no second decision.
    p_window_once_r2: assert property (@(posedge clk) disable iff (rst)
        (boot_halt || boot_run) |=> !(boot_halt || boot_run));

endmodule

// File: rtl/dbg_pend_unit.sv
module dbg_pend_unit #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic         clr_i,
    output logic [N-1:0] pend_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            logic q;
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= set_i[g] | (q & ~clr_i);
            end
            assign pend_o[g] = q;
        end
    endgenerate

    p_taken_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> (pend_o == '0));

endmodule

// File: rtl/dbg_src_reg.sv
module dbg_src_reg
    import dbg_halt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [CODE_W-1:0] take_code,
    input  logic              take_bkpt,
    input  logic              take_trace,
    input  logic              rd_clr,
    input  logic              go_clr,
    output halt_src_t         src_o,
    output logic              trace_o
);
    halt_src_t src_q;
    logic      trace_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= '0;
            trace_q <= 1'b0;
        end else if (take) begin
            src_q.code <= take_code;
            src_q.bkpt <= take_bkpt | (src_q.bkpt & ~rd_clr);
            if (take_trace) trace_q <= 1'b1;
        end else begin
            if (rd_clr || go_clr) src_q.code <= CODE_NONE;
            if (rd_clr)           src_q.bkpt <= 1'b0;
            if (go_clr)           trace_q    <= 1'b0;
        end
    end

    assign src_o   = src_q;
    assign trace_o = trace_q;

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !take) |=> (src_o == '0));

    p_go_keeps_bkpt_r7: assert property (@(posedge clk) disable iff (rst)
        (go_clr && !rd_clr && !take) |=> (src_o.code == CODE_NONE && src_o.bkpt == $past(src_o.bkpt) && !trace_o));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int RST_LOW_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dbg_pin_n,
    input  logic       bgnd_cmd,
    input  logic       go_cmd,
    input  logic       pc_write,
    input  logic       stat_read,
    input  logic       trace_full,
    input  logic       bkpt_hit,
    input  logic       insn_sample,
    input  logic       stop_enter,
    input  logic       dbg_enable,
    input  logic       secure,
    output logic       halt_req,
    output logic [1:0] core_status,
    output logic [3:0] halt_src,
    output logic       bkpt_flag,
    output logic       trace_halt_flag,
    output logic       resume_vld,
    output logic [1:0] resume_sel,
    output logic       illegal_rsp
);
    core_st_e st_q, st_d;

    logic cmd_ok;
    logic boot_halt, boot_run;
    logic [NUM_PEND-1:0] pend_set, pend_q;
    logic take_boot, take_stop, take_pend, take_any;
    logic [CODE_W-1:0] take_code;
    logic go_ok, go_bad, pcw_ok, pcw_bad, bg_bad;
    logic from_reset_q, pc_loaded_q;
    resume_e resume_q;
    halt_src_t src;

    assign cmd_ok = dbg_enable && !secure;

    dbg_rst_entry #(.MIN_LOW(RST_LOW_CYCLES)) u_rst_entry (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (dbg_pin_n),
        .boot_halt (boot_halt),
        .boot_run  (boot_run)
    );

    always_comb begin
        pend_set          = '0;
        pend_set[PEND_BG] = (st_q == ST_RUN) && bgnd_cmd && cmd_ok;
        pend_set[PEND_TR] = (st_q == ST_RUN) && trace_full;
        pend_set[PEND_BK] = (st_q == ST_RUN) && bkpt_hit;
    end

    dbg_pend_unit #(.N(NUM_PEND)) u_pend (
        .clk    (clk),
        .rst    (rst),
        .set_i  (pend_set),
        .clr_i  (take_pend),
        .pend_o (pend_q)
    );

    assign take_boot = (st_q == ST_BOOT) && boot_halt;
    assign take_stop = (st_q == ST_STOP) && bgnd_cmd && cmd_ok;
    assign take_pend = (st_q == ST_RUN) && insn_sample && (|pend_q);
    assign take_any  = take_boot || take_stop || take_pend;

    always_comb begin
        if (take_boot)      take_code = CODE_PIN;
        else if (take_stop) take_code = CODE_FIRST + CODE_W'(PEND_BG);
        else                take_code = pick_code(pend_q);
    end

    assign go_ok   = (st_q == ST_HALT) && go_cmd   && !secure;
    assign go_bad  = (st_q == ST_HALT) && go_cmd   &&  secure;
    assign pcw_ok  = (st_q == ST_HALT) && pc_write && !secure;
    assign pcw_bad = (st_q == ST_HALT) && pc_write &&  secure;
    assign bg_bad  = bgnd_cmd && !cmd_ok;

    dbg_src_reg u_src (
        .clk        (clk),
        .rst        (rst),
        .take       (take_any),
        .take_code  (take_code),
        .take_bkpt  (take_pend && (pend_q[PEND_TR] || pend_q[PEND_BK])),
        .take_trace (take_pend && pend_q[PEND_TR]),
        .rd_clr     (stat_read),
        .go_clr     (go_ok),
        .src_o      (src),
        .trace_o    (trace_halt_flag)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_BOOT: begin
                if (boot_halt)     st_d = ST_HALT;
                else if (boot_run) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (take_pend)       st_d = ST_HALT;
                else if (stop_enter) st_d = ST_STOP;
            end
            ST_STOP: if (take_stop) st_d = ST_HALT;
            ST_HALT: if (go_ok)     st_d = ST_RUN;
            default: st_d = ST_BOOT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_BOOT;
            from_reset_q <= 1'b0;
            pc_loaded_q  <= 1'b0;
            resume_vld   <= 1'b0;
            resume_q     <= RS_NEXT;
            illegal_rsp  <= 1'b0;
            core_status  <= 2'd0;
        end else begin
            st_q        <= st_d;
            core_status <= status_of(st_q);
            illegal_rsp <= bg_bad || go_bad || pcw_bad;
            resume_vld  <= go_ok;
            if (go_ok) begin
                if (pc_loaded_q)       resume_q <= RS_LOADED_PC;
                else if (from_reset_q) resume_q <= RS_RESET_FLOW;
                else                   resume_q <= RS_NEXT;
            end else begin
                resume_q <= RS_NEXT;
            end
            if (go_ok)          from_reset_q <= 1'b0;
            else if (take_boot) from_reset_q <= 1'b1;
            if (go_ok)          pc_loaded_q  <= 1'b0;
            else if (pcw_ok)    pc_loaded_q  <= 1'b1;
        end
    end

    assign halt_req   = (st_q == ST_HALT);
    assign halt_src   = src;
    assign bkpt_flag  = src.bkpt;
    assign resume_sel = resume_q;

    // A halt out of the running state only happens at a sample strobe.
    p_halt_at_sample_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_RUN && st_q == ST_HALT) |-> $past(insn_sample));

    p_status_lags_r12: assert property (@(posedge clk) disable iff (rst)
        $rose(halt_req) |=> (core_status == 2'd2));

    p_bad_bg_r10: assert property (@(posedge clk) disable iff (rst)
        (bgnd_cmd && !dbg_enable) |=> illegal_rsp);

    p_secure_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (halt_req && secure && go_cmd) |=> (halt_req && illegal_rsp));

    p_resume_runs_r7: assert property (@(posedge clk) disable iff (rst)
        resume_vld |-> !halt_req);

    p_stop_exit_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ST_STOP && halt_req) |-> (halt_src[2:0] == 3'd2));

endmodule

// File: tb/dbg_halt_ctrl_bench.sv
module dbg_halt_ctrl_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dbg_pin_n = 1'b1;
    logic bgnd_cmd = 0, go_cmd = 0, pc_write = 0, stat_read = 0;
    logic trace_full = 0, bkpt_hit = 0, insn_sample = 0, stop_enter = 0;
    logic dbg_enable = 1'b1, secure = 1'b0;
    logic       halt_req;
    logic [1:0] core_status;
    logic [3:0] halt_src;
    logic       bkpt_flag, trace_halt_flag, resume_vld, illegal_rsp;
    logic [1:0] resume_sel;

    always #5 clk = ~clk;

    dbg_halt_ctrl u_dbg_halt_ctrl (
        .clk(clk), .rst(rst), .dbg_pin_n(dbg_pin_n), .bgnd_cmd(bgnd_cmd),
        .go_cmd(go_cmd), .pc_write(pc_write), .stat_read(stat_read),
        .trace_full(trace_full), .bkpt_hit(bkpt_hit), .insn_sample(insn_sample),
        .stop_enter(stop_enter), .dbg_enable(dbg_enable), .secure(secure),
        .halt_req(halt_req), .core_status(core_status), .halt_src(halt_src),
        .bkpt_flag(bkpt_flag), .trace_halt_flag(trace_halt_flag),
        .resume_vld(resume_vld), .resume_sel(resume_sel), .illegal_rsp(illegal_rsp)
    );

    localparam int BG = 1, GO = 2, PCW = 4, RD = 8, TR = 16, BK = 32, SMP = 64, STP = 128;

    int n_chk = 0, n_fail = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference: 0 boot, 1 run, 2 stop, 3 halt
    int ms = 0, mlow = 0, p_bg = 0, p_tr = 0, p_bk = 0;
    int mcode = 0, mbk = 0, mtr = 0, mfr = 0, mpcl = 0;
    int mill = 0, mvld = 0, msel = 0, mstat = 0;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            ms = 0; mlow = 0; p_bg = 0; p_tr = 0; p_bk = 0;
            mcode = 0; mbk = 0; mtr = 0; mfr = 0; mpcl = 0;
            mill = 0; mvld = 0; msel = 0; mstat = 0;
        end else begin
            int ns, tk, tcode, tb, tt, ok, gok, pend_taken;
            ok = dbg_enable && !secure;
            ns = ms; tk = 0; tcode = 0; tb = 0; tt = 0; pend_taken = 0;
            gok = (ms == 3) && go_cmd && !secure;
            mill = (bgnd_cmd && !ok) || ((ms == 3) && (go_cmd || pc_write) && secure);
            mstat = (ms == 2) ? 1 : (ms == 3) ? 2 : 0;
            if (ms == 0) begin
                if (!dbg_pin_n) begin
                    if (mlow + 1 >= 2) begin tk = 1; tcode = 1; ns = 3; mfr = 1; end
                    else mlow = mlow + 1;
                end else ns = 1;
            end else if (ms == 1) begin
                if (insn_sample && (p_bg || p_tr || p_bk)) begin
                    tk = 1; pend_taken = 1; ns = 3;
                    tcode = p_bg ? 2 : (p_tr ? 3 : 4);
                    tb = p_tr || p_bk; tt = p_tr;
                end else if (stop_enter) ns = 2;
            end else if (ms == 2) begin
                if (bgnd_cmd && ok) begin tk = 1; tcode = 2; ns = 3; end
            end else begin
                if (gok) ns = 1;
            end
            if (ms == 1) begin
                if (pend_taken) begin p_bg = 0; p_tr = 0; p_bk = 0; end
                if (bgnd_cmd && ok) p_bg = 1;
                if (trace_full) p_tr = 1;
                if (bkpt_hit) p_bk = 1;
            end
            if (tk) begin
                mcode = tcode;
                mbk = tb || (mbk && !stat_read);
                if (tt) mtr = 1;
            end else begin
                if (stat_read || gok) mcode = 0;
                if (stat_read) mbk = 0;
                if (gok) mtr = 0;
            end
            mvld = gok;
            msel = gok ? (mpcl ? 1 : (mfr ? 2 : 0)) : 0;
            if (gok) begin mfr = 0; mpcl = 0; end
            else if (ms == 3 && pc_write && !secure) mpcl = 1;
            ms = ns;
        end
    end

    task automatic cmp(input string tag, input string nm, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started && !done) begin
            cmp("R3",  "halt_req",        int'(halt_req), (ms == 3) ? 1 : 0);
            cmp("R12", "core_status",     int'(core_status), mstat);
            cmp("R4",  "halt_src",        int'(halt_src), mbk * 8 + mcode);
            cmp("R5",  "bkpt_flag",       int'(bkpt_flag), mbk);
            cmp("R5",  "trace_halt_flag", int'(trace_halt_flag), mtr);
            cmp("R9",  "resume_vld",      int'(resume_vld), mvld);
            cmp("R9",  "resume_sel",      int'(resume_sel), msel);
            cmp("R10", "illegal_rsp",     int'(illegal_rsp), mill);
        end
    end

    task automatic one_cycle(input int s);
        bgnd_cmd = s[0]; go_cmd = s[1]; pc_write = s[2]; stat_read = s[3];
        trace_full = s[4]; bkpt_hit = s[5]; insn_sample = s[6]; stop_enter = s[7];
        @(negedge clk); #1;
        {bgnd_cmd, go_cmd, pc_write, stat_read, trace_full, bkpt_hit, insn_sample, stop_enter} = '0;
    endtask

    task automatic reset_low(input int low_after);
        rst = 1; dbg_pin_n = (low_after > 0) ? 1'b0 : 1'b1;
        one_cycle(0); one_cycle(0);
        rst = 0;
        for (int k = 0; k < low_after; k++) one_cycle(0);
        dbg_pin_n = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk); #1;
        one_cycle(0); one_cycle(0);
        cmp("R1", "reset halt_req", int'(halt_req), 0);
        cmp("R1", "reset src", int'(halt_src), 0);
        cmp("R1", "reset status", int'(core_status), 0);
        cmp("R1", "reset illegal", int'(illegal_rsp), 0);
        rst = 0;
        one_cycle(0); one_cycle(0);
        cmp("R2", "pin high runs", int'(halt_req), 0);

        one_cycle(STP); one_cycle(0);
        cmp("R13", "stop status", int'(core_status), 1);
        one_cycle(BG);
        cmp("R8", "stop exit halt", int'(halt_req), 1);
        cmp("R8", "stop exit code", int'(halt_src), 2);
        one_cycle(GO);
        cmp("R8", "resume next sel", int'(resume_sel), 0);
        cmp("R9", "resume vld", int'(resume_vld), 1);

        one_cycle(BG);
        cmp("R3", "bg pends", int'(halt_req), 0);
        one_cycle(0);
        cmp("R3", "no sample no halt", int'(halt_req), 0);
        one_cycle(SMP);
        cmp("R3", "halt at sample", int'(halt_req), 1);
        one_cycle(RD);
        cmp("R6", "read clears", int'(halt_src), 0);
        one_cycle(GO);

        one_cycle(BG | TR | BK); one_cycle(SMP);
        cmp("R4", "priority", int'(halt_src), 4'b1010);
        cmp("R5", "trace flag", int'(trace_halt_flag), 1);
        one_cycle(GO);
        cmp("R7", "go partial clear", int'(halt_src), 4'b1000);
        cmp("R7", "go clears trace", int'(trace_halt_flag), 0);
        cmp("R7", "go runs", int'(halt_req), 0);
        one_cycle(RD);

        one_cycle(TR | SMP);
        cmp("R3", "same-cycle sample ignored", int'(halt_req), 0);
        one_cycle(SMP);
        cmp("R4", "trace code", int'(halt_src), 4'b1011);
        one_cycle(GO); one_cycle(RD);

        one_cycle(BK); one_cycle(SMP);
        cmp("R5", "bkpt sets flag", int'(halt_src), 4'b1100);
        cmp("R5", "bkpt no trace", int'(trace_halt_flag), 0);
        one_cycle(GO); one_cycle(RD);

        dbg_enable = 0;
        one_cycle(BG);
        cmp("R10", "disabled illegal", int'(illegal_rsp), 1);
        one_cycle(SMP);
        cmp("R10", "disabled no halt", int'(halt_req), 0);
        dbg_enable = 1; secure = 1;
        one_cycle(BG);
        cmp("R10", "secure illegal", int'(illegal_rsp), 1);
        secure = 0;
        one_cycle(SMP);
        cmp("R10", "secure no halt", int'(halt_req), 0);

        rst = 1; dbg_pin_n = 0; one_cycle(0); one_cycle(0); rst = 0;
        one_cycle(0);
        cmp("R2", "one low edge", int'(halt_req), 0);
        one_cycle(0);
        cmp("R2", "pin halt", int'(halt_req), 1);
        cmp("R2", "pin code", int'(halt_src), 1);
        dbg_pin_n = 1;
        one_cycle(PCW); one_cycle(GO);
        cmp("R9", "loaded pc", int'(resume_sel), 1);

        reset_low(2); one_cycle(GO);
        cmp("R9", "reset flow", int'(resume_sel), 2);

        reset_low(2); secure = 1;
        one_cycle(GO);
        cmp("R11", "go refused", int'(illegal_rsp), 1);
        cmp("R11", "stays halted", int'(halt_req), 1);
        one_cycle(PCW);
        cmp("R11", "pcw refused", int'(illegal_rsp), 1);
        one_cycle(RD);
        cmp("R11", "read works", int'(halt_src), 0);
        secure = 0;
        one_cycle(GO);
        cmp("R11", "refused pcw not loaded", int'(resume_sel), 2);

        reset_low(1); one_cycle(0);
        cmp("R2", "short low runs", int'(halt_req), 0);
        cmp("R12", "run status", int'(core_status), 0);

        for (int i = 0; i < 4000; i++) begin
            int s;
            s = 0;
            if ($urandom_range(0, 9) == 0) s |= BG;
            if ($urandom_range(0, 5) == 0) s |= GO;
            if ($urandom_range(0, 9) == 0) s |= PCW;
            if ($urandom_range(0, 7) == 0) s |= RD;
            if ($urandom_range(0, 15) == 0) s |= TR;
            if ($urandom_range(0, 15) == 0) s |= BK;
            if ($urandom_range(0, 2) == 0) s |= SMP;
            if ($urandom_range(0, 19) == 0) s |= STP;
            if ($urandom_range(0, 49) == 0) secure = ~secure;
            if ($urandom_range(0, 49) == 0) dbg_enable = ~dbg_enable;
            dbg_pin_n = ($urandom_range(0, 2) != 0);
            rst = ($urandom_range(0, 199) == 0);
            one_cycle(s);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule